// File: doc/BRIEF.md
# Register Move and Swap Eliminator

This block sits in the rename stage. Each cycle it is offered a request made of one or two destination registers and the same number of source registers. One of each is a plain register copy. Two of each is an exchange of two registers. The block decides at once whether the request can be absorbed without allocating physical registers. When it can, the destination register, and every register that renames into the same full register, is recorded as an alias of the source. No new mapping is created.

Per-register attributes arrive as flat input vectors:
- the register file that owns the register;
- a rename target, where 0 means the register renames as itself;
- a flag that permits elimination.

A separate mask says which registers currently hold zero. Each register file has a parameterised budget of eliminations per rename cycle, and can be set to accept only copies of zero-valued registers. A plain, non-eliminated write to a register removes the alias of its group. Scheduling and retirement are handled elsewhere.

Top module: `mov_swap_elim`

## Requirements
- R1: A request is eliminated only when its destination count equals its source count and that count is 1 or 2. Counts of 0, 3 and unequal counts are rejected.
- R2: Register ID 0 means "no register". A request that names register 0 as any active source or destination is rejected, and an alias entry of 0 means "not aliased".
- R3: The owning file of every active source and destination must equal the file of destination 0, or the request is rejected.
- R4: The request is rejected when the permit flag of the destination's effective register is 0. The effective register is the rename target when that target is nonzero, and the register itself otherwise.
- R5: A partial write is rejected unless its `req_clr_upper` bit (bit j for destination j) is 1. A partial write is a destination whose rename target is nonzero and differs from the destination.
- R6: In a file whose bit in FILE_ZERO_ONLY is 1, every source must have its `zero_mask` bit set, or the request is rejected.
- R7: Each file counts the eliminations it has committed since the last `cyc_start`. A request of N pairs is rejected when that count plus N exceeds the file's nonzero limit in FILE_MAX_ELIM. A limit of 0 means no limit. `cyc_start` zeroes the count seen by the request in the same cycle.
- R8: Source i is paired with destination N-1-i. For an exchange, source 0 feeds destination 1 and source 1 feeds destination 0.
- R9: On elimination, the alias entry of each pair's effective destination, and of every register whose rename target is that register, becomes the source's effective register. If that register already has a nonzero alias, the alias is used instead. All lookups use the table as it stood before the request, and a rejected request changes no entry.
- R10: When a request is eliminated, `rd_zero[i]` equals the zero bit of source i. `wr_zero[j]` equals the zero bit of the source paired with destination j. Both outputs are 0 otherwise.
- R11: A plain write (`wr_plain_valid`) to a nonzero register clears the alias entries of that register's effective register and of every register renaming into it.
- R12: Reset clears every alias entry and every per-file count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | First cycle of a rename cycle; zeroes the per-file counts |
| req_valid | input | 1 | Request present |
| req_nwr | input | 2 | Number of destinations |
| req_nrd | input | 2 | Number of sources |
| req_wr0 | input | REG_W | Destination 0 |
| req_wr1 | input | REG_W | Destination 1 |
| req_rd0 | input | REG_W | Source 0 |
| req_rd1 | input | REG_W | Source 1 |
| req_clr_upper | input | 2 | Per destination: write clears the upper part of its full register |
| reg_file_map | input | NUM_REGS*FILE_W | Owning file of each register |
| reg_ren_map | input | NUM_REGS*REG_W | Rename target of each register, 0 = itself |
| reg_allow_map | input | NUM_REGS | Elimination permitted for each register |
| zero_mask | input | NUM_REGS | Register currently known to hold zero |
| wr_plain_valid | input | 1 | A non-eliminated write occurs |
| wr_plain_reg | input | REG_W | Register of the plain write |
| elim_ok | output | 1 | Request is eliminated this cycle |
| wr_zero | output | 2 | Per destination: eliminated write is a zero write |
| rd_zero | output | 2 | Per source: eliminated read is a zero read |
| alias_map | output | NUM_REGS*REG_W | Alias entry of each register, 0 = none |

## Verification
The bench targets exchanges. If the pairing is straight rather than crosswise, the two destinations receive each other's aliases and the zero flags land on the wrong bits. An exchange of two registers that already alias each other exposes a table that updates one pair before reading the other: one entry ends up pointing at the wrong register. The per-cycle budget is exhausted and then reopened, both by `cyc_start` and by reset. A design that counts rejected requests, or ignores the budget, accepts or refuses the wrong move. Partial writes with and without the clear-upper bit, register 0, cross-file pairs, a barred destination and zero-only files each have a vector. Each vector must reject only for its intended reason.

// File: rtl/mse_pkg.sv
package mse_pkg;

   // a request carries at most this many (source, destination) pairs
   localparam int PAIRS = 2;

   // outcome of the individual tests applied to one pair
   typedef struct packed {
      logic same_file;
      logic permitted;
      logic full_write;
      logic zero_ok;
   } pair_verdict_t;

endpackage

// File: rtl/mse_pair_check.sv
module mse_pair_check
   import mse_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int NUM_FILES = 2,
   parameter int REG_W = 4,
   parameter int FILE_W = 1,
   parameter logic [NUM_FILES-1:0] ZERO_ONLY = '0
) (
   input  logic [REG_W-1:0]           rd_reg,
   input  logic [REG_W-1:0]           wr_reg,
   input  logic                       wr_clr_upper,
   input  logic [FILE_W-1:0]          ref_file,
   input  logic [NUM_REGS*FILE_W-1:0] reg_file_map,
   input  logic [NUM_REGS*REG_W-1:0]  reg_ren_map,
   input  logic [NUM_REGS-1:0]        reg_allow_map,
   input  logic [NUM_REGS-1:0]        zero_mask,
   output logic                       pair_ok,
   output logic                       src_zero,
   output logic [REG_W-1:0]           dst_eff,
   output logic [REG_W-1:0]           src_eff
);

   logic [FILE_W-1:0] rd_file, wr_file;
   logic [REG_W-1:0]  rd_ren, wr_ren;
   logic              file_zero_only;
   pair_verdict_t     verdict;

   assign rd_file = reg_file_map[rd_reg*FILE_W +: FILE_W];
   assign wr_file = reg_file_map[wr_reg*FILE_W +: FILE_W];
   assign rd_ren  = reg_ren_map[rd_reg*REG_W +: REG_W];
   assign wr_ren  = reg_ren_map[wr_reg*REG_W +: REG_W];

   assign dst_eff  = (wr_ren == '0) ? wr_reg : wr_ren;
   assign src_eff  = (rd_ren == '0) ? rd_reg : rd_ren;
   assign src_zero = zero_mask[rd_reg];

   always_comb begin
      file_zero_only = 1'b0;
      for (int f = 0; f < NUM_FILES; f++) begin
         if (ref_file == FILE_W'(f)) file_zero_only = ZERO_ONLY[f];
      end
   end

   always_comb begin
      verdict.same_file  = (rd_file == ref_file) && (wr_file == ref_file);
      verdict.permitted  = reg_allow_map[dst_eff];
      verdict.full_write = (wr_ren == '0) || (wr_ren == wr_reg) || wr_clr_upper;
      verdict.zero_ok    = !file_zero_only || src_zero;
   end

   assign pair_ok = &verdict;

endmodule

// File: rtl/mse_budget.sv
module mse_budget #(
   parameter int NUM_FILES = 2,
   parameter int FILE_W = 1,
   parameter int CNT_W = 4,
   parameter logic [NUM_FILES*CNT_W-1:0] MAX_ELIM = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic [FILE_W-1:0] file,
   input  logic [1:0]        n_pairs,
   input  logic              commit,
   output logic              room
);

   localparam int SUM_W = CNT_W + 1;

   logic [NUM_FILES-1:0] room_vec;

   for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
      localparam logic [CNT_W-1:0] LIMIT = MAX_ELIM[f*CNT_W +: CNT_W];

      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] base;
      logic [SUM_W-1:0] want;

      assign base = cyc_start ? '0 : cnt_q;
      assign want = {1'b0, base} + SUM_W'(n_pairs);

      if (LIMIT == '0) begin : g_unlimited
         assign room_vec[f] = 1'b1;
      end else begin : g_limited
         assign room_vec[f] = (want <= {1'b0, LIMIT});
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (commit && (file == FILE_W'(f))) begin
            cnt_q <= want[CNT_W-1:0];
         end else if (cyc_start) begin
            cnt_q <= '0;
         end
      end
   end

   always_comb begin
      room = 1'b0;
      for (int f = 0; f < NUM_FILES; f++) begin
         if (file == FILE_W'(f)) room = room_vec[f];
      end
   end

endmodule

// File: rtl/mse_alias_table.sv
module mse_alias_table
   import mse_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int REG_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        commit,
   input  logic [PAIRS-1:0]            pair_act,
   input  logic [PAIRS-1:0][REG_W-1:0] dst_eff,
   input  logic [PAIRS-1:0][REG_W-1:0] src_eff,
   input  logic                        clr_valid,
   input  logic [REG_W-1:0]            clr_reg,
   input  logic [NUM_REGS*REG_W-1:0]   reg_ren_map,
   output logic [NUM_REGS*REG_W-1:0]   alias_map
);

   logic [REG_W-1:0] alias_q [NUM_REGS];
   logic [REG_W-1:0] alias_d [NUM_REGS];
   logic [PAIRS-1:0][REG_W-1:0] src_final;
   logic [REG_W-1:0] clr_ren, clr_tgt;

   // resolve through an existing alias using the table before this request
   for (genvar p = 0; p < PAIRS; p++) begin : g_resolve
      assign src_final[p] = (alias_q[src_eff[p]] != '0) ? alias_q[src_eff[p]] : src_eff[p];
   end

   assign clr_ren = reg_ren_map[clr_reg*REG_W +: REG_W];
   assign clr_tgt = (clr_ren == '0) ? clr_reg : clr_ren;

   always_comb begin
      for (int r = 0; r < NUM_REGS; r++) alias_d[r] = alias_q[r];
      if (clr_valid && (clr_reg != '0)) begin
         for (int r = 0; r < NUM_REGS; r++) begin
            if ((REG_W'(r) == clr_tgt) || (reg_ren_map[r*REG_W +: REG_W] == clr_tgt))
               alias_d[r] = '0;
         end
      end
      if (commit) begin
         for (int p = 0; p < PAIRS; p++) begin
            if (pair_act[p]) begin
               for (int r = 0; r < NUM_REGS; r++) begin
                  if ((REG_W'(r) == dst_eff[p]) || (reg_ren_map[r*REG_W +: REG_W] == dst_eff[p]))
                     alias_d[r] = src_final[p];
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REGS; r++) alias_q[r] <= '0;
      end else begin
         for (int r = 0; r < NUM_REGS; r++) alias_q[r] <= alias_d[r];
      end
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_flat
      assign alias_map[r*REG_W +: REG_W] = alias_q[r];
   end

endmodule

// File: rtl/mov_swap_elim.sv
module mov_swap_elim
   import mse_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int NUM_FILES = 2,
   parameter int CNT_W = 4,
   parameter logic [NUM_FILES*CNT_W-1:0] FILE_MAX_ELIM = {4'd0, 4'd2},
   parameter logic [NUM_FILES-1:0] FILE_ZERO_ONLY = 2'b10,
   localparam int REG_W = $clog2(NUM_REGS),
   localparam int FILE_W = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cyc_start,
   input  logic                       req_valid,
   input  logic [1:0]                 req_nwr,
   input  logic [1:0]                 req_nrd,
   input  logic [REG_W-1:0]           req_wr0,
   input  logic [REG_W-1:0]           req_wr1,
   input  logic [REG_W-1:0]           req_rd0,
   input  logic [REG_W-1:0]           req_rd1,
   input  logic [1:0]                 req_clr_upper,
   input  logic [NUM_REGS*FILE_W-1:0] reg_file_map,
   input  logic [NUM_REGS*REG_W-1:0]  reg_ren_map,
   input  logic [NUM_REGS-1:0]        reg_allow_map,
   input  logic [NUM_REGS-1:0]        zero_mask,
   input  logic                       wr_plain_valid,
   input  logic [REG_W-1:0]           wr_plain_reg,
   output logic                       elim_ok,
   output logic [1:0]                 wr_zero,
   output logic [1:0]                 rd_zero,
   output logic [NUM_REGS*REG_W-1:0]  alias_map
);

   if (NUM_REGS < 4 || (1 << REG_W) != NUM_REGS) begin : g_bad_regs
      $error("mov_swap_elim: NUM_REGS must be a power of two of at least 4");
   end
   if (NUM_FILES < 1 || CNT_W < 2) begin : g_bad_files
      $error("mov_swap_elim: need at least one file and a 2-bit counter");
   end

   logic                        shape_ok, two, nonzero_ok, pair_pass, room;
   logic [FILE_W-1:0]           ref_file;
   logic [PAIRS-1:0]            pair_act, pair_ok, pair_zero;
   logic [PAIRS-1:0][REG_W-1:0] dst_eff, src_eff;
   logic [REG_W-1:0]            rd_arr [PAIRS];
   logic [REG_W-1:0]            wr_arr [PAIRS];

   assign rd_arr[0] = req_rd0;
   assign rd_arr[1] = req_rd1;
   assign wr_arr[0] = req_wr0;
   assign wr_arr[1] = req_wr1;

   // R1: equal counts of one or two
   assign shape_ok = (req_nwr == req_nrd) && (req_nwr != 2'd0) && (req_nwr != 2'd3);
   assign two      = (req_nwr == 2'd2);
   assign pair_act = {two, 1'b1};

   // R2: register 0 is not a register
   assign nonzero_ok = (req_wr0 != '0) && (req_rd0 != '0) &&
                       (!two || ((req_wr1 != '0) && (req_rd1 != '0)));

   assign ref_file = reg_file_map[req_wr0*FILE_W +: FILE_W];

   // R8: source p feeds destination N-1-p
   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      logic [REG_W-1:0] wr_sel;
      logic             clr_sel;
      assign wr_sel  = two ? wr_arr[PAIRS-1-p] : wr_arr[p];
      assign clr_sel = two ? req_clr_upper[PAIRS-1-p] : req_clr_upper[p];

      mse_pair_check #(
         .NUM_REGS (NUM_REGS),
         .NUM_FILES(NUM_FILES),
         .REG_W    (REG_W),
         .FILE_W   (FILE_W),
         .ZERO_ONLY(FILE_ZERO_ONLY)
      ) u_chk (
         .rd_reg       (rd_arr[p]),
         .wr_reg       (wr_sel),
         .wr_clr_upper (clr_sel),
         .ref_file     (ref_file),
         .reg_file_map (reg_file_map),
         .reg_ren_map  (reg_ren_map),
         .reg_allow_map(reg_allow_map),
         .zero_mask    (zero_mask),
         .pair_ok      (pair_ok[p]),
         .src_zero     (pair_zero[p]),
         .dst_eff      (dst_eff[p]),
         .src_eff      (src_eff[p])
      );
   end

   assign pair_pass = &(pair_ok | ~pair_act);

   mse_budget #(
      .NUM_FILES(NUM_FILES),
      .FILE_W   (FILE_W),
      .CNT_W    (CNT_W),
      .MAX_ELIM (FILE_MAX_ELIM)
   ) u_budget (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_start(cyc_start),
      .file     (ref_file),
      .n_pairs  (req_nwr),
      .commit   (elim_ok),
      .room     (room)
   );

   assign elim_ok = req_valid && shape_ok && nonzero_ok && pair_pass && room;

   // R10: zero flags follow the pairing
   always_comb begin
      wr_zero = '0;
      rd_zero = '0;
      if (elim_ok) begin
         for (int p = 0; p < PAIRS; p++) begin
            if (pair_act[p]) begin
               rd_zero[p] = pair_zero[p];
               if (two) wr_zero[PAIRS-1-p] = pair_zero[p];
               else     wr_zero[p]         = pair_zero[p];
            end
         end
      end
   end

   mse_alias_table #(
      .NUM_REGS(NUM_REGS),
      .REG_W   (REG_W)
   ) u_alias (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (elim_ok),
      .pair_act   (pair_act),
      .dst_eff    (dst_eff),
      .src_eff    (src_eff),
      .clr_valid  (wr_plain_valid),
      .clr_reg    (wr_plain_reg),
      .reg_ren_map(reg_ren_map),
      .alias_map  (alias_map)
   );

endmodule

// File: rtl/mse_chk.sv
module mse_chk #(
   parameter int NUM_REGS = 16,
   parameter int REG_W = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic [1:0]                req_nwr,
   input logic [1:0]                req_nrd,
   input logic [REG_W-1:0]          req_wr0,
   input logic [REG_W-1:0]          req_rd0,
   input logic                      wr_plain_valid,
   input logic                      elim_ok,
   input logic [1:0]                wr_zero,
   input logic [1:0]                rd_zero,
   input logic [NUM_REGS*REG_W-1:0] alias_map
);

   // R1
   shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_nwr != req_nrd) || (req_nwr == 2'd0) || (req_nwr == 2'd3)) |-> !elim_ok);

   // R2
   reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elim_ok |-> (req_valid && (req_wr0 != '0) && (req_rd0 != '0)));

   // R9
   table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!elim_ok && !wr_plain_valid) |=> $stable(alias_map));

   // R10
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !elim_ok |-> ((wr_zero == 2'b00) && (rd_zero == 2'b00)));

   // R12
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (alias_map == '0));

endmodule

bind mov_swap_elim mse_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_mse_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_nwr       (req_nwr),
   .req_nrd       (req_nrd),
   .req_wr0       (req_wr0),
   .req_rd0       (req_rd0),
   .wr_plain_valid(wr_plain_valid),
   .elim_ok       (elim_ok),
   .wr_zero       (wr_zero),
   .rd_zero       (rd_zero),
   .alias_map     (alias_map)
);

// File: tb/sim_mov_swap_elim.sv
module sim_mov_swap_elim;

   localparam int NR = 16;
   localparam int RW = 4;
   localparam int NV = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_start = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_nwr = '0, req_nrd = '0;
   logic [RW-1:0] req_wr0 = '0, req_wr1 = '0, req_rd0 = '0, req_rd1 = '0;
   logic [1:0] req_clr_upper = '0;
   logic [NR-1:0] reg_file_map;
   logic [NR*RW-1:0] reg_ren_map;
   logic [NR-1:0] reg_allow_map;
   logic [NR-1:0] zero_mask;
   logic wr_plain_valid = 1'b0;
   logic [RW-1:0] wr_plain_reg = '0;
   logic elim_ok;
   logic [1:0] wr_zero, rd_zero;
   logic [NR*RW-1:0] alias_map;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   mov_swap_elim u0 (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .req_valid(req_valid),
      .req_nwr(req_nwr), .req_nrd(req_nrd),
      .req_wr0(req_wr0), .req_wr1(req_wr1), .req_rd0(req_rd0), .req_rd1(req_rd1),
      .req_clr_upper(req_clr_upper), .reg_file_map(reg_file_map),
      .reg_ren_map(reg_ren_map), .reg_allow_map(reg_allow_map), .zero_mask(zero_mask),
      .wr_plain_valid(wr_plain_valid), .wr_plain_reg(wr_plain_reg),
      .elim_ok(elim_ok), .wr_zero(wr_zero), .rd_zero(rd_zero), .alias_map(alias_map)
   );

   // attributes: regs 0..7 in file 0 (limit 2), 8..15 in file 1 (no limit, zero-only);
   // reg 3 renames as 2, reg 11 renames as 10; reg 5 barred; regs 7, 9, 14 hold zero
   initial begin
      reg_file_map = 16'hFF00;
      reg_ren_map = '0;
      reg_ren_map[3*RW +: RW] = 4'd2;
      reg_ren_map[11*RW +: RW] = 4'd10;
      reg_allow_map = ~(16'h1 << 5);
      zero_mask = (16'h1 << 7) | (16'h1 << 9) | (16'h1 << 14);
   end

   // {req, cs, nwr, nrd, wr0, wr1, rd0, rd1, clr, expected elim_ok}
   localparam logic [27:0] VEC [NV] = '{
      {4'd9,  1'b1, 2'd1, 2'd1, 4'd1,  4'd0, 4'd2,  4'd0, 2'b00, 1'b1}, // R9 move 1<-2
      {4'd9,  1'b0, 2'd1, 2'd1, 4'd4,  4'd0, 4'd1,  4'd0, 2'b00, 1'b1}, // R9 chained source
      {4'd7,  1'b0, 2'd1, 2'd1, 4'd6,  4'd0, 4'd7,  4'd0, 2'b00, 1'b0}, // R7 budget spent
      {4'd8,  1'b1, 2'd2, 2'd2, 4'd6,  4'd7, 4'd6,  4'd7, 2'b00, 1'b1}, // R8 swap 6,7
      {4'd7,  1'b0, 2'd1, 2'd1, 4'd2,  4'd0, 4'd1,  4'd0, 2'b00, 1'b0}, // R7 budget spent
      {4'd1,  1'b1, 2'd2, 2'd1, 4'd1,  4'd2, 4'd4,  4'd0, 2'b00, 1'b0}, // R1 unequal
      {4'd1,  1'b1, 2'd0, 2'd0, 4'd1,  4'd0, 4'd2,  4'd0, 2'b00, 1'b0}, // R1 empty
      {4'd1,  1'b1, 2'd3, 2'd3, 4'd1,  4'd2, 4'd4,  4'd6, 2'b00, 1'b0}, // R1 three
      {4'd4,  1'b1, 2'd1, 2'd1, 4'd5,  4'd0, 4'd1,  4'd0, 2'b00, 1'b0}, // R4 barred dest
      {4'd3,  1'b1, 2'd1, 2'd1, 4'd1,  4'd0, 4'd9,  4'd0, 2'b00, 1'b0}, // R3 cross file
      {4'd5,  1'b1, 2'd1, 2'd1, 4'd3,  4'd0, 4'd7,  4'd0, 2'b00, 1'b0}, // R5 partial
      {4'd5,  1'b0, 2'd1, 2'd1, 4'd3,  4'd0, 4'd7,  4'd0, 2'b01, 1'b1}, // R5 clears upper
      {4'd6,  1'b1, 2'd1, 2'd1, 4'd8,  4'd0, 4'd9,  4'd0, 2'b00, 1'b1}, // R6 zero source
      {4'd6,  1'b0, 2'd1, 2'd1, 4'd10, 4'd0, 4'd12, 4'd0, 2'b00, 1'b0}, // R6 nonzero source
      {4'd2,  1'b0, 2'd1, 2'd1, 4'd0,  4'd0, 4'd2,  4'd0, 2'b00, 1'b0}, // R2 reg 0
      {4'd7,  1'b0, 2'd1, 2'd1, 4'd12, 4'd0, 4'd14, 4'd0, 2'b00, 1'b1}, // R7 unlimited
      {4'd7,  1'b0, 2'd1, 2'd1, 4'd13, 4'd0, 4'd14, 4'd0, 2'b00, 1'b1}, // R7 unlimited
      {4'd7,  1'b0, 2'd1, 2'd1, 4'd15, 4'd0, 4'd9,  4'd0, 2'b00, 1'b1}  // R7 unlimited
   };

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int alias_of(input int r);
      return int'(alias_map[r*RW +: RW]);
   endfunction

   task automatic drive(input logic cs, input logic [1:0] nw, input logic [1:0] nr,
                        input logic [3:0] w0, input logic [3:0] w1,
                        input logic [3:0] r0, input logic [3:0] r1, input logic [1:0] cu);
      @(negedge clk);
      cyc_start = cs; req_valid = 1'b1; req_nwr = nw; req_nrd = nr;
      req_wr0 = w0; req_wr1 = w1; req_rd0 = r0; req_rd1 = r1; req_clr_upper = cu;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      cyc_start = 1'b0; req_valid = 1'b0; wr_plain_valid = 1'b0;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   int exp_alias [NR];

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R12 reset state
      check("R12 reset alias table", int'(alias_map == '0), 1);
      check("R12 idle elim_ok", int'(elim_ok), 0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][23], VEC[i][22:21], VEC[i][20:19], VEC[i][18:15], VEC[i][14:11],
               VEC[i][10:7], VEC[i][6:3], VEC[i][2:1]);
         tests++;
         if (elim_ok != VEC[i][0]) begin
            fails++;
            $display("FAIL R%0d vector %0d: actual %0d expected %0d",
                     VEC[i][27:24], i, elim_ok, VEC[i][0]);
         end
      end
      idle();

      // R9 table after the vectors
      for (int r = 0; r < NR; r++) exp_alias[r] = 0;
      exp_alias[1] = 2;  exp_alias[4] = 2;  exp_alias[6] = 7;  exp_alias[7] = 6;
      exp_alias[2] = 6;  exp_alias[3] = 6;  exp_alias[8] = 9;  exp_alias[12] = 14;
      exp_alias[13] = 14; exp_alias[15] = 9;
      for (int r = 0; r < NR; r++) check($sformatf("R9 alias of %0d", r), alias_of(r), exp_alias[r]);

      // R11 plain write to reg 3 clears its whole group
      @(negedge clk);
      wr_plain_valid = 1'b1; wr_plain_reg = 4'd3;
      idle();
      check("R11 alias of 2", alias_of(2), 0);
      check("R11 alias of 3", alias_of(3), 0);
      check("R11 alias of 1 kept", alias_of(1), 2);

      // R8 R10 crosswise swap: rd0=7 (zero) feeds wr1=4, rd1=2 feeds wr0=1
      drive(1'b1, 2'd2, 2'd2, 4'd1, 4'd4, 4'd7, 4'd2, 2'b11);
      check("R8 swap accepted", int'(elim_ok), 1);
      check("R10 wr_zero", int'(wr_zero), 2);
      check("R10 rd_zero", int'(rd_zero), 1);
      idle();
      check("R8 alias of 4 via 7", alias_of(4), 6);
      check("R8 alias of 1", alias_of(1), 2);

      // R9 swap of two mutually aliased registers resolves against the old table
      drive(1'b1, 2'd2, 2'd2, 4'd6, 4'd7, 4'd6, 4'd7, 2'b00);
      check("R9 swap accepted", int'(elim_ok), 1);
      idle();
      check("R9 atomic alias of 7", alias_of(7), 7);
      check("R9 atomic alias of 6", alias_of(6), 6);

      // R12 reset mid-run clears table and budget
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R12 alias cleared", int'(alias_map == '0), 1);
      drive(1'b0, 2'd1, 2'd1, 4'd1, 4'd0, 4'd2, 4'd0, 2'b00);
      check("R12 budget move 1", int'(elim_ok), 1);
      drive(1'b0, 2'd1, 2'd1, 4'd4, 4'd0, 4'd2, 4'd0, 2'b00);
      check("R12 budget move 2", int'(elim_ok), 1);
      drive(1'b0, 2'd1, 2'd1, 4'd6, 4'd0, 4'd2, 4'd0, 2'b00);
      check("R7 budget move 3 refused", int'(elim_ok), 0);
      check("R10 refused flags", int'(wr_zero) + int'(rd_zero), 0);
      idle();
      check("R9 refused leaves 6", alias_of(6), 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule